// File: doc/BRIEF.md
# Watermark Write-Drain Read/Write Scheduler

This block arbitrates one shared, two-way memory data bus between read traffic and write traffic. Reads go out on the bus as soon as the scheduler is serving reads. Writes are not sent at once. They are parked in an internal first-in first-out write queue. Each cycle the block can put one command on a downstream command port, and a direction flag on that port tells the memory side which way the data bus will be driven.

Once the queue fills up to a high watermark, the scheduler turns the bus around. It then empties writes back to back, and pending reads are refused, until the occupancy comes down to a low watermark. After that it turns the bus back and resumes reads. When no read is waiting and the queue holds data, the scheduler can also drain writes opportunistically. An opportunistic drain ends as soon as a read shows up, unless the queue has meanwhile reached the high watermark. Each change of direction costs a fixed number of idle turnaround cycles.

Top module: `wdrain_sched`

## Requirements
- R1: During reset and right after it, bus_mode is 0 (read), cmd_valid is low, wr_ready is high and rd_ready is high.
- R2: In read mode with a read waiting and occupancy below HIGH_WM, the read is accepted and issued in the same cycle (cmd_valid high, cmd_is_write low, cmd_addr equal to rd_addr), and no write is issued.
- R3: If occupancy, sampled at the start of a cycle in read mode, is at or above HIGH_WM, the next cycle enters the read-to-write turnaround, and a drain follows it.
- R4: In a forced drain, one write is issued every cycle while occupancy exceeds LOW_WM, whatever the read requests are. The first cycle in which occupancy is at or below LOW_WM issues nothing and starts the write-to-read turnaround.
- R5: rd_ready is low and no read is issued whenever bus_mode is not 0, and also in read mode when occupancy is at or above HIGH_WM.
- R6: Every turnaround, in either direction, lasts exactly TURN_CYCLES cycles. During it bus_mode is 1 and cmd_valid stays low.
- R7: A cycle never issues both a read and a write. cmd_is_write is 1 for a write and 0 for a read.
- R8: wr_ready is low exactly when the queue holds DEPTH entries, and a write offered then is not stored.
- R9: Writes leave in the order they were accepted, each with the address and data it was accepted with.
- R10: In read mode with no read waiting and a non-empty queue, the next cycle starts a turnaround into an opportunistic drain. That drain issues writes only while no read is waiting and the queue is non-empty, and it leaves after the first cycle where that fails.
- R11: If occupancy reaches HIGH_WM during an opportunistic drain, the drain becomes forced and continues down to LOW_WM even when reads arrive.
- R12: bus_mode encodes 0 for read mode, 1 for turnaround and 2 for write drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read accepted (and issued) this cycle when rd_valid |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write queue can take a write |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_is_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | AW | Command address |
| cmd_wdata | output | DW | Write data of a write command |
| bus_mode | output | 2 | 0 read, 1 turnaround, 2 drain |

## Verification
The bench first applies steady reads with light writes, which shows that writes stay parked below the high watermark. Continuous writes under read pressure then force a drain that has to ignore reads and fill the queue to full during the turnaround. Complete silence on both request inputs shows the opportunistic drain emptying the queue. A read arriving mid-drain separates an opportunistic exit from a forced one, and a queue that climbs to the high watermark while draining opportunistically checks the promotion to a forced drain. A long pseudo-random mix ends the run, and a behavioural model compares every output on every cycle.

// File: rtl/wds_pkg.sv
// Package: shared types of the write-drain scheduler.
// Assumes nothing beyond being compiled before the modules that import it.
package wds_pkg;

    // Internal scheduler phase.
    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_TO_WR = 2'd1,
        ST_DRAIN = 2'd2,
        ST_TO_RD = 2'd3
    } sched_state_e;

    // Encodings seen on the bus_mode port.
    localparam logic [1:0] MODE_READ  = 2'd0;
    localparam logic [1:0] MODE_TURN  = 2'd1;
    localparam logic [1:0] MODE_DRAIN = 2'd2;

endpackage

// File: rtl/wds_wfifo.sv
// Module: write queue, a synchronous FIFO with an occupancy count.
// What it does: stores {address, data} words and shows the oldest one on head_data.
// Assumes: DEPTH >= 2; the caller never pushes when full or pops when empty.
module wds_wfifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 48,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_ptr_nxt;
    logic [PW-1:0]    rd_ptr_nxt;

    // Pointer advance: natural wrap for a power-of-two depth, explicit wrap otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : gen_pow2_wrap
            assign wr_ptr_nxt = wr_ptr + 1'b1;
            assign rd_ptr_nxt = rd_ptr + 1'b1;
        end else begin : gen_cmp_wrap
            assign wr_ptr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_data = mem[rd_ptr];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr_nxt;
            end
            if (pop) begin
                rd_ptr <= rd_ptr_nxt;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);                                                    // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);                                                    // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));                                               // R8

endmodule

// File: rtl/wds_turn_timer.sv
// Module: turnaround timer.
// What it does: after start it holds done low for TURN_CYCLES-1 cycles, so a
// phase that waits on done lasts exactly TURN_CYCLES cycles.
// Assumes: TURN_CYCLES >= 1; start comes only while the timer is idle.
module wds_turn_timer #(
    parameter int TURN_CYCLES = 6,
    localparam int TW         = $clog2(TURN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    logic [TW-1:0] remain;

    assign done = (remain == '0);

    // Load on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= TW'(TURN_CYCLES - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> done);                                                    // R6

endmodule

// File: rtl/wds_ctrl.sv
// Module: scheduler state machine.
// What it does: picks read service, turnaround or write drain, and decides
// whether a read or a write is issued this cycle.
// Assumes: LOW_WM < HIGH_WM <= queue depth; occupancy is the registered count.
module wds_ctrl
    import wds_pkg::*;
#(
    parameter int HIGH_WM = 28,
    parameter int LOW_WM  = 8,
    parameter int CW      = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [CW-1:0] occ,
    input  logic         rd_valid,
    input  logic         turn_done,
    output sched_state_e state,
    output logic         rd_ready,
    output logic         rd_go,
    output logic         wr_go,
    output logic         turn_start
);

    sched_state_e state_d;
    logic         forced_q;
    logic         forced_d;
    logic         at_high;
    logic         forced_eff;
    logic         occ_nz;

    assign at_high    = (occ >= CW'(HIGH_WM));
    assign occ_nz     = (occ != '0);
    assign forced_eff = forced_q | at_high;

    // Read acceptance: only in read mode and below the high watermark.
    assign rd_ready = (state == ST_READ) && !at_high;
    assign rd_go    = rd_ready && rd_valid;

    // Write issue during a drain: forced drains run to LOW_WM, opportunistic ones yield to reads.
    always_comb begin
        wr_go = 1'b0;
        if (state == ST_DRAIN) begin
            if (forced_eff) begin
                wr_go = (occ > CW'(LOW_WM));
            end else begin
                wr_go = occ_nz && !rd_valid;
            end
        end
    end

    // Next phase, drain kind and turnaround start.
    always_comb begin
        state_d    = state;
        forced_d   = forced_q;
        turn_start = 1'b0;
        unique case (state)
            ST_READ: begin
                if (at_high) begin
                    state_d    = ST_TO_WR;
                    forced_d   = 1'b1;
                    turn_start = 1'b1;
                end else if (!rd_valid && occ_nz) begin
                    state_d    = ST_TO_WR;
                    forced_d   = 1'b0;
                    turn_start = 1'b1;
                end
            end
            ST_TO_WR: begin
                if (turn_done) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                forced_d = forced_eff;
                if (!wr_go) begin
                    state_d    = ST_TO_RD;
                    turn_start = 1'b1;
                end
            end
            ST_TO_RD: begin
                if (turn_done) begin
                    state_d = ST_READ;
                end
            end
            default: state_d = ST_READ;
        endcase
    end

    // Phase and drain-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READ;
            forced_q <= 1'b0;
        end else begin
            state    <= state_d;
            forced_q <= forced_d;
        end
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go && wr_go));                                                 // R7
    AST_HIGH_STARTS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && at_high) |=> (state == ST_TO_WR));             // R3
    AST_DRAIN_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DRAIN) |-> ($past(state) == ST_TO_WR));           // R6
    AST_READ_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_READ) |-> ($past(state) == ST_TO_RD));            // R6
    AST_FORCED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && forced_eff && occ > CW'(LOW_WM)) |-> wr_go);  // R11

endmodule

// File: rtl/wdrain_sched.sv
// Module: top of the watermark write-drain scheduler.
// What it does: queues writes, issues reads directly, and drains writes in
// batches between HIGH_WM and LOW_WM with TURN_CYCLES idle cycles per switch.
// Assumes: 2 <= DEPTH, 0 <= LOW_WM < HIGH_WM <= DEPTH, TURN_CYCLES >= 1.
module wdrain_sched
    import wds_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int HIGH_WM     = 28,
    parameter int LOW_WM      = 8,
    parameter int TURN_CYCLES = 6,
    parameter int AW          = 16,
    parameter int DW          = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          cmd_valid,
    output logic          cmd_is_write,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    output logic [1:0]    bus_mode
);

    localparam int EW = AW + DW;
    localparam int CW = $clog2(DEPTH + 1);

    sched_state_e  state;
    logic          q_push;
    logic          q_full;
    logic          q_empty;
    logic [EW-1:0] q_head;
    logic [CW-1:0] q_count;
    logic          rd_go;
    logic          wr_go;
    logic          turn_start;
    logic          turn_done;

    assign wr_ready = !q_full;
    assign q_push   = wr_valid && !q_full;

    wds_wfifo #(
        .DEPTH (DEPTH),
        .WIDTH (EW)
    ) u_wfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({wr_addr, wr_data}),
        .pop       (wr_go),
        .head_data (q_head),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty)
    );

    wds_turn_timer #(
        .TURN_CYCLES (TURN_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (turn_start),
        .done  (turn_done)
    );

    wds_ctrl #(
        .HIGH_WM (HIGH_WM),
        .LOW_WM  (LOW_WM),
        .CW      (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .occ        (q_count),
        .rd_valid   (rd_valid),
        .turn_done  (turn_done),
        .state      (state),
        .rd_ready   (rd_ready),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .turn_start (turn_start)
    );

    // Command port: a write takes the queue head, otherwise the incoming read.
    always_comb begin
        cmd_valid    = rd_go || wr_go;
        cmd_is_write = wr_go;
        cmd_addr     = wr_go ? q_head[EW-1:DW] : rd_addr;
        cmd_wdata    = wr_go ? q_head[DW-1:0] : '0;
    end

    // Mode report for the status port.
    always_comb begin
        unique case (state)
            ST_READ:  bus_mode = MODE_READ;
            ST_DRAIN: bus_mode = MODE_DRAIN;
            default:  bus_mode = MODE_TURN;
        endcase
    end

    AST_TURN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == MODE_TURN) |-> !cmd_valid);                            // R6
    AST_READ_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_is_write) |-> (bus_mode == MODE_READ));          // R5
    AST_WRITE_ONLY_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_write) |-> (bus_mode == MODE_DRAIN));          // R12
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !q_empty);                                                // R9

endmodule

// File: tb/wdrain_sched_bench.sv
// Bench: drives phased stimulus and compares every output on every cycle with
// a behavioural model built from queues and integers.
module wdrain_sched_bench;

    localparam int DEPTH = 32;
    localparam int HIGH  = 28;
    localparam int LOW   = 8;
    localparam int TURN  = 6;
    localparam int AW    = 16;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_ready;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          cmd_valid;
    logic          cmd_is_write;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [1:0]    bus_mode;

    int checks = 0;
    int errors = 0;

    // Model state.
    int                   m_mode = 0;
    int                   m_tc = 0;
    bit                   m_forced = 1'b0;
    logic [AW+DW-1:0]     m_q[$];

    // Observations for directed checks.
    int  turn_run = 0;
    int  last_turn_run = 0;
    int  bad_turn_runs = 0;
    int  turn_runs_seen = 0;
    bit  saw_full = 1'b0;
    int  writes_seen = 0;
    int  writes_with_rd = 0;
    bit  saw_drain_code = 1'b0;
    int  wseq = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    wdrain_sched #(
        .DEPTH(DEPTH), .HIGH_WM(HIGH), .LOW_WM(LOW),
        .TURN_CYCLES(TURN), .AW(AW), .DW(DW)
    ) u_wdrain_sched (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bus_mode(bus_mode)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Set request inputs for the coming cycle; write payload follows a sequence.
    task automatic drive(input bit rv, input bit wv);
        rd_valid = rv;
        rd_addr  = rd_addr + 16'd3;
        wr_valid = wv;
        wr_addr  = AW'(wseq);
        wr_data  = DW'(wseq * 7 + 32'h1000);
    endtask

    // One cycle: compare against the model, then advance the model at the edge.
    task automatic step();
        int  sz;
        bit  at_h, e_rdr, e_wrr, rdgo, wrgo, feff, push;
        int  e_bus;
        logic [AW-1:0] e_addr;
        #1;
        sz    = m_q.size();
        at_h  = (sz >= HIGH);
        e_wrr = (sz < DEPTH);
        e_rdr = (m_mode == 0) && !at_h;
        rdgo  = e_rdr && rd_valid;
        feff  = m_forced || at_h;
        wrgo  = (m_mode == 2) && (feff ? (sz > LOW) : (sz > 0 && !rd_valid));
        e_bus = (m_mode == 0) ? 0 : ((m_mode == 2) ? 2 : 1);
        e_addr = wrgo ? m_q[0][AW+DW-1:DW] : rd_addr;

        chk(bus_mode == 2'(e_bus), "R3 bus_mode", bus_mode, e_bus);
        chk(rd_ready == e_rdr, "R5 rd_ready", rd_ready, e_rdr);
        chk(wr_ready == e_wrr, "R8 wr_ready", wr_ready, e_wrr);
        chk(cmd_valid == (rdgo || wrgo), "R6 cmd_valid", cmd_valid, rdgo || wrgo);
        chk(cmd_is_write == wrgo, "R4 cmd_is_write", cmd_is_write, wrgo);
        if (rdgo || wrgo) begin
            chk(cmd_addr == e_addr, "R9 cmd_addr", cmd_addr, e_addr);
        end
        if (wrgo) begin
            chk(cmd_wdata == m_q[0][DW-1:0], "R9 cmd_wdata", cmd_wdata, m_q[0][DW-1:0]);
        end
        if (rd_valid && rd_ready) begin
            chk(!cmd_is_write, "R7 read cycle carries write flag", cmd_is_write, 0);
        end

        // Observations.
        if (!wr_ready) saw_full = 1'b1;
        if (bus_mode == 2'd2) saw_drain_code = 1'b1;
        if (cmd_valid && cmd_is_write) begin
            writes_seen++;
            if (rd_valid) writes_with_rd++;
        end
        if (bus_mode == 2'd1) begin
            turn_run++;
        end else if (turn_run != 0) begin
            last_turn_run = turn_run;
            turn_runs_seen++;
            if (turn_run != TURN) bad_turn_runs++;
            turn_run = 0;
        end

        push = wr_valid && e_wrr;
        @(posedge clk);
        case (m_mode)
            0: begin
                if (at_h) begin
                    m_mode = 1; m_forced = 1'b1; m_tc = TURN;
                end else if (!rd_valid && sz > 0) begin
                    m_mode = 1; m_forced = 1'b0; m_tc = TURN;
                end
            end
            1: begin
                if (m_tc == 1) m_mode = 2; else m_tc--;
            end
            2: begin
                m_forced = feff;
                if (!wrgo) begin
                    m_mode = 3; m_tc = TURN;
                end
            end
            default: begin
                if (m_tc == 1) m_mode = 0; else m_tc--;
            end
        endcase
        if (wrgo) void'(m_q.pop_front());
        if (push) begin
            m_q.push_back({wr_addr, wr_data});
            wseq++;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input bit rv, input bit wv);
        for (int i = 0; i < n; i++) begin
            drive(rv, wv);
            step();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int w0;
        // R1: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk(bus_mode == 2'd0, "R1 bus_mode in reset", bus_mode, 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", cmd_valid, 0);
        chk(wr_ready == 1'b1, "R1 wr_ready in reset", wr_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(rd_ready == 1'b1, "R1 rd_ready after reset", rd_ready, 1);
        chk(bus_mode == 2'd0, "R1 bus_mode after reset", bus_mode, 0);
        @(negedge clk);

        // R2: steady reads with light writes never issue a write.
        w0 = writes_seen;
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, i[0]);
            step();
        end
        chk(writes_seen == w0, "R2 writes issued under read load", writes_seen - w0, 0);

        // R3, R4, R8: continuous writes under read pressure force a drain.
        run(60, 1'b1, 1'b1);
        chk(saw_full, "R8 queue reached full", saw_full, 1);
        chk(writes_with_rd > 0, "R4 drain ignores waiting reads", writes_with_rd, 1);
        run(40, 1'b1, 1'b0);
        chk(bus_mode == 2'd0, "R4 back to read after drain", bus_mode, 0);
        chk(last_turn_run == TURN, "R6 turnaround length", last_turn_run, TURN);

        // R10: silence empties the queue opportunistically.
        run(40, 1'b0, 1'b0);
        chk(saw_drain_code, "R12 drain code observed", saw_drain_code, 1);
        chk(bus_mode == 2'd0, "R10 idle returns to read", bus_mode, 0);

        // R10: a read arriving ends an opportunistic drain early.
        for (int i = 0; i < 12; i++) begin
            drive(i > 8, i < 12);
            step();
        end
        run(30, 1'b1, 1'b0);
        chk(bus_mode == 2'd0, "R10 read arrival ends drain", bus_mode, 0);

        // R11: opportunistic drain promoted to forced by reaching HIGH_WM.
        run(30, 1'b0, 1'b0);
        run(27, 1'b1, 1'b1);
        run(8, 1'b0, 1'b1);
        w0 = writes_with_rd;
        run(60, 1'b1, 1'b0);
        chk(writes_with_rd > w0, "R11 promoted drain continues with reads", writes_with_rd - w0, 1);

        // Pseudo-random mix.
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5]);
            step();
        end
        chk(turn_runs_seen > 0 && bad_turn_runs == 0, "R6 all turnaround runs",
            bad_turn_runs, 0);

        summary();
        $finish;
    end

endmodule